// File: doc/BRIEF.md
# Windowed Key-Sequence Watchdog

This block is a watchdog timer for a processor subsystem. Software sets a 3-bit rate, a window-enable bit, a stop-run bit and a wait-hold bit through one control write. The rate selects one of seven time-out periods, and a rate of zero turns the watchdog off. While the watchdog is enabled, a counter advances once per input clock. Software keeps the system alive by writing two key bytes to the arm port, 0x55 first and then 0xAA. The counter restarts on the clock edge that accepts 0xAA.

The block raises a one-clock reset request in four cases: the counter reaches the end of the period, software writes a byte that is not a key, 0xAA arrives without a 0x55 before it, or, with the window enabled, a key write arrives before the last quarter of the period. The counter clock can be held off in two power states. In the pseudo-stop state the counter stops unless stop-run is set. In the wait state the counter stops only when wait-hold is set.

The arm port is a valid/ready input that never applies back-pressure. `arm_ready` is always high, so each cycle with `arm_valid` high delivers exactly one byte. While the watchdog is disabled, those bytes are accepted and discarded.

Top module: `guard_wdt`

## Requirements
- R1: After reset, or while the rate field is 000, the counter stays at zero. Bytes written to the arm port are discarded, and `wdt_reset` stays low.
- R2: The period in input clocks is 2^(B) for rate 001, 2^(B+2) for 010, 2^(B+4) for 011, 2^(B+6) for 100, 2^(B+8) for 101, 2^(B+9) for 110 and 2^(B+10) for 111, where B is `BASE_LOG2`. After a restart, if the counter takes that many counting clocks with no service, `wdt_reset` is high in the cycle after the last of them.
- R3: `wdt_reset` is a single-cycle pulse, and the count starts again from zero after a time-out.
- R4: Writing 0x55 and then 0xAA, in separate transfers, returns the counter to zero at the edge that accepts 0xAA. No request is raised.
- R5: An accepted byte other than 0x55 or 0xAA raises `wdt_reset` in the next cycle.
- R6: An accepted 0xAA that does not follow a 0x55 raises a request. Writing 0x55 again after a 0x55 keeps the sequence armed and raises no request.
- R7: With window enable set, an arm write raises a request when the count is below P - P/4, where P is the period. A write at or above that count is handled normally.
- R8: While `sys_pstop` is high, the counter is frozen unless stop-run is set.
- R9: While `sys_wait` is high and wait-hold is set, the counter is frozen. With wait-hold clear, the wait state has no effect.
- R10: A 0xAA that completes the sequence in the same cycle as the final count wins: no time-out request is raised, and the counter restarts.
- R11: A control write clears the count and any half-entered key sequence. `arm_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock that drives the counter |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_rate | input | 3 | Time-out rate; 000 disables the watchdog |
| cfg_window | input | 1 | Window enable |
| cfg_stop_run | input | 1 | Keep counting in the pseudo-stop state |
| cfg_wait_hold | input | 1 | Freeze the counter in the wait state |
| arm_valid | input | 1 | Arm byte is present |
| arm_ready | output | 1 | Always 1; no back-pressure |
| arm_data | input | 8 | Arm byte |
| sys_wait | input | 1 | System is in the wait state |
| sys_pstop | input | 1 | System is in the pseudo-stop state |
| wdt_reset | output | 1 | One-cycle reset request |

## Verification
All results are registered once. A request caused by an arm byte shows up on `wdt_reset` in the cycle after the edge that accepts the byte. The bench drives each byte at a falling edge and samples at the next falling edge. A time-out request shows up in the cycle after the P-th counting edge following a restart. The bench counts P-1 falling edges after the restart, where the output must still be low, then checks for high at the P-th and for low again at the next. Window checks place the write when the count is exactly P - P/4 - 1 and exactly P - P/4, so the bench hits both sides of the boundary.

// File: rtl/guard_wdt_pkg.sv
package guard_wdt_pkg;
  localparam int RATE_W = 3;
  localparam int KEY_W  = 8;
  localparam logic [KEY_W-1:0] KEY_OPEN  = 8'h55;
  localparam logic [KEY_W-1:0] KEY_CLOSE = 8'hAA;
  localparam int MAX_EXTRA = 10;

  typedef enum logic {KS_IDLE, KS_OPEN} key_state_t;

  // extra doubling stages beyond the base period for each rate code
  function automatic int unsigned rate_extra(input int unsigned rate);
    if (rate == 0)      return 0;
    else if (rate <= 5) return 2 * (rate - 1);
    else if (rate == 6) return 9;
    else                return 10;
  endfunction
endpackage

// File: rtl/guard_wdt_period.sv
module guard_wdt_period
  import guard_wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int CNT_W     = BASE_LOG2 + MAX_EXTRA
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic              en_o,
  output logic [CNT_W-1:0]  last_o,
  output logic [CNT_W-1:0]  win_start_o
);
  localparam int NRATE = 1 << RATE_W;

  logic [CNT_W-1:0] last_tab  [NRATE];
  logic [CNT_W-1:0] start_tab [NRATE];

  for (genvar g = 0; g < NRATE; g++) begin : g_rate
    if (g == 0) begin : g_off
      assign last_tab[g]  = '0;
      assign start_tab[g] = '0;
    end else begin : g_on
      localparam int LG = BASE_LOG2 + int'(rate_extra(g));
      assign last_tab[g]  = CNT_W'((64'd1 << LG) - 64'd1);
      assign start_tab[g] = CNT_W'(64'd3 << (LG - 2));
    end
  end

  assign en_o        = (rate_i != '0);
  assign last_o      = last_tab[rate_i];
  assign win_start_o = start_tab[rate_i];
endmodule

// File: rtl/guard_wdt_counter.sv
module guard_wdt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (tick_i) begin
      if (cnt_q == last_i)   cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = tick_i && (cnt_q == last_i);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i) |=> $stable(cnt_q));

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/guard_wdt_keychk.sv
module guard_wdt_keychk
  import guard_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             fire_i,
  input  logic [KEY_W-1:0] data_i,
  input  logic             win_en_i,
  input  logic             in_win_i,
  output logic             service_o,
  output logic             fault_o
);
  key_state_t state_q, state_d;

  always_comb begin
    state_d   = state_q;
    service_o = 1'b0;
    fault_o   = 1'b0;
    if (fire_i) begin
      if (win_en_i && !in_win_i) begin
        fault_o = 1'b1;
        state_d = KS_IDLE;
      end else if (data_i == KEY_OPEN) begin
        state_d = KS_OPEN;
      end else if (data_i == KEY_CLOSE && state_q == KS_OPEN) begin
        service_o = 1'b1;
        state_d   = KS_IDLE;
      end else begin
        fault_o = 1'b1;
        state_d = KS_IDLE;
      end
    end
    if (clear_i) state_d = KS_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KS_IDLE;
    else         state_q <= state_d;
  end

  assert_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(service_o && fault_o));

  assert_open_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !clear_i && !fault_o && data_i == KEY_OPEN) |=> (state_q == KS_OPEN));
endmodule

// File: rtl/guard_wdt.sv
module guard_wdt
  import guard_wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_window,
  input  logic              cfg_stop_run,
  input  logic              cfg_wait_hold,
  input  logic              arm_valid,
  output logic              arm_ready,
  input  logic [KEY_W-1:0]  arm_data,
  input  logic              sys_wait,
  input  logic              sys_pstop,
  output logic              wdt_reset
);
  localparam int CNT_W = BASE_LOG2 + MAX_EXTRA;

  logic [RATE_W-1:0] rate_q;
  logic              win_q, stop_run_q, wait_hold_q;
  logic              enabled, tick, arm_fire, in_win;
  logic              service, fault, expire, clr_cnt, req_q;
  logic [CNT_W-1:0]  cnt, period_last, win_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q      <= '0;
      win_q       <= 1'b0;
      stop_run_q  <= 1'b0;
      wait_hold_q <= 1'b0;
    end else if (cfg_we) begin
      rate_q      <= cfg_rate;
      win_q       <= cfg_window;
      stop_run_q  <= cfg_stop_run;
      wait_hold_q <= cfg_wait_hold;
    end
  end

  guard_wdt_period #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) period_i (
    .rate_i      (rate_q),
    .en_o        (enabled),
    .last_o      (period_last),
    .win_start_o (win_start)
  );

  assign tick = enabled
              && !(sys_pstop && !stop_run_q)
              && !(sys_wait && wait_hold_q);

  assign arm_ready = 1'b1;
  assign arm_fire  = arm_valid && arm_ready && enabled;
  assign in_win    = (cnt >= win_start);
  assign clr_cnt   = cfg_we || service || fault;

  guard_wdt_counter #(.CNT_W(CNT_W)) counter_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .clear_i  (clr_cnt),
    .last_i   (period_last),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  guard_wdt_keychk keychk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (cfg_we),
    .fire_i    (arm_fire),
    .data_i    (arm_data),
    .win_en_i  (win_q),
    .in_win_i  (in_win),
    .service_o (service),
    .fault_o   (fault)
  );

  // a completed key sequence outranks a simultaneous expiry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= fault || (expire && !service);
  end

  assign wdt_reset = req_q;

  assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled |-> (cnt == '0));

  assert_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled |=> !wdt_reset);

  assert_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enabled |-> (cnt <= period_last));

  assert_badkey_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_fire && arm_data != KEY_OPEN && arm_data != KEY_CLOSE) |=> wdt_reset);

  assert_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_fire && win_q && cnt < win_start) |=> wdt_reset);
endmodule

// File: tb/guard_wdt_tb_top.sv
module guard_wdt_tb_top;
  localparam int BASE = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_rate = '0;
  logic       cfg_window = 1'b0, cfg_stop_run = 1'b0, cfg_wait_hold = 1'b0;
  logic       arm_valid = 1'b0;
  logic       arm_ready;
  logic [7:0] arm_data = '0;
  logic       sys_wait = 1'b0, sys_pstop = 1'b0;
  logic       wdt_reset;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  guard_wdt #(.BASE_LOG2(BASE)) dut_i (
    .clk_i, .rst_ni, .cfg_we, .cfg_rate, .cfg_window, .cfg_stop_run,
    .cfg_wait_hold, .arm_valid, .arm_ready, .arm_data, .sys_wait,
    .sys_pstop, .wdt_reset
  );

  typedef struct packed {
    logic [2:0] rate;
    logic       win;
    logic [7:0] idle;
    logic [7:0] key;
    logic       exp;
  } vec_t;

  // period 16 (rate 1): window from 12; period 64 (rate 2): window from 48
  localparam vec_t VECS [10] = '{
    '{3'd1, 1'b0, 8'd3,  8'h55, 1'b0},  // R4 first key accepted
    '{3'd1, 1'b0, 8'd3,  8'h12, 1'b1},  // R5
    '{3'd1, 1'b0, 8'd3,  8'hAA, 1'b1},  // R6 close without open
    '{3'd1, 1'b1, 8'd5,  8'h55, 1'b1},  // R7 early
    '{3'd1, 1'b1, 8'd12, 8'h55, 1'b0},  // R7 window edge
    '{3'd1, 1'b1, 8'd11, 8'h55, 1'b1},  // R7 one before
    '{3'd0, 1'b0, 8'd3,  8'h12, 1'b0},  // R1 ignored when off
    '{3'd2, 1'b1, 8'd47, 8'h55, 1'b1},  // R7 rate 2 one before
    '{3'd2, 1'b1, 8'd48, 8'h55, 1'b0},  // R7 rate 2 edge
    '{3'd1, 1'b0, 8'd15, 8'h00, 1'b1}   // R5 zero byte
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: wdt_reset actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  // called at a falling edge; returns at a falling edge with count cleared
  task automatic cfg(input logic [2:0] r, input logic w, input logic sr, input logic wh);
    cfg_we = 1'b1; cfg_rate = r; cfg_window = w;
    cfg_stop_run = sr; cfg_wait_hold = wh;
    @(posedge clk_i);
    @(negedge clk_i);
    cfg_we = 1'b0;
  endtask

  task automatic arm(input logic [7:0] d);
    arm_valid = 1'b1; arm_data = d;
    @(posedge clk_i);
    @(negedge clk_i);
    arm_valid = 1'b0;
  endtask

  task automatic expect_timeout(input string req, input int p);
    idle(p - 1); check(req, wdt_reset, 1'b0);
    idle(1);     check(req, wdt_reset, 1'b1);
    idle(1);     check("R3", wdt_reset, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset", wdt_reset, 1'b0);
    check("R11 ready", arm_ready, 1'b1);
    rst_ni = 1'b1;
    idle(2);
    arm(8'h33);
    check("R1 off after reset", wdt_reset, 1'b0);
    idle(40);
    check("R1 no timeout off", wdt_reset, 1'b0);

    foreach (VECS[i]) begin
      cfg(VECS[i].rate, VECS[i].win, 1'b0, 1'b0);
      idle(int'(VECS[i].idle));
      arm(VECS[i].key);
      check($sformatf("R5/R6/R7 vector %0d", i), wdt_reset, VECS[i].exp);
    end

    // R2 timeouts
    cfg(3'd1, 1'b0, 1'b0, 1'b0);
    expect_timeout("R2 rate1", 16);
    cfg(3'd2, 1'b0, 1'b0, 1'b0);
    expect_timeout("R2 rate2", 64);

    // R4 service restarts count
    cfg(3'd1, 1'b0, 1'b0, 1'b0);
    idle(10);
    arm(8'h55); check("R4 open", wdt_reset, 1'b0);
    arm(8'hAA); check("R4 close", wdt_reset, 1'b0);
    expect_timeout("R4 restarted", 16);

    // R6 double open then close
    cfg(3'd1, 1'b0, 1'b0, 1'b0);
    arm(8'h55); arm(8'h55);
    check("R6 double open", wdt_reset, 1'b0);
    arm(8'hAA);
    check("R6 close after double", wdt_reset, 1'b0);

    // R11 control write drops half sequence
    cfg(3'd1, 1'b0, 1'b0, 1'b0);
    arm(8'h55);
    cfg(3'd1, 1'b0, 1'b0, 1'b0);
    arm(8'hAA);
    check("R11 cleared key state", wdt_reset, 1'b1);

    // R10 service on final count
    cfg(3'd1, 1'b0, 1'b0, 1'b0);
    idle(14);
    arm(8'h55);
    arm(8'hAA);
    check("R10 service wins", wdt_reset, 1'b0);
    expect_timeout("R10 restarted", 16);

    // R7 full service inside window
    cfg(3'd1, 1'b1, 1'b0, 1'b0);
    idle(12);
    arm(8'h55); arm(8'hAA);
    check("R7 in window service", wdt_reset, 1'b0);

    // R8 pseudo-stop gating
    sys_pstop = 1'b1;
    cfg(3'd1, 1'b0, 1'b0, 1'b0);
    idle(40);
    check("R8 frozen", wdt_reset, 1'b0);
    sys_pstop = 1'b0;
    expect_timeout("R8 resumes", 16);
    sys_pstop = 1'b1;
    cfg(3'd1, 1'b0, 1'b1, 1'b0);
    expect_timeout("R8 stop-run", 16);
    sys_pstop = 1'b0;

    // R9 wait gating
    sys_wait = 1'b1;
    cfg(3'd1, 1'b0, 1'b0, 1'b1);
    idle(40);
    check("R9 frozen", wdt_reset, 1'b0);
    cfg(3'd1, 1'b0, 1'b0, 1'b0);
    expect_timeout("R9 no hold", 16);
    sys_wait = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule